// File: doc/BRIEF.md
# Phase-Continuous FSK Tone Modulator

This block is the digital transmit core of a half-duplex 1200 bps voiceband modem. It turns a serial data level into a phase-continuous tone and presents it as a signed 8-bit sine-amplitude word, one word per sample strobe, for an external DAC and reconstruction filter. Every frequency comes from the 3.579545 MHz master clock. A 24-bit phase accumulator advances by a frequency word on each sample strobe. The top bits of the accumulator address a quarter-wave sine table. A configuration input picks one of two tone plans. In the second plan, an answer-tone request replaces the data tones with a fixed 2025 Hz tone.

Output is gated by an active-low request-to-send input, under a three-state controller. In `ST_IDLE` the gain is zero and the output rests at mid-code. Transition IDLE→SEND happens when request-to-send becomes active, and the gain goes straight to full scale. Transition SEND→RAMP happens when request-to-send is released. In `ST_RAMP` the gain falls linearly, one fixed step per sample strobe, over the turn-off interval. Transition RAMP→IDLE happens when the gain would reach zero. Transition RAMP→SEND happens when request-to-send becomes active again, and the gain returns to full. Data has no bit clock and may change at any rate from 0 to 1200 bps. Only the phase increment follows it, so tone changes never break the phase.

The data, request-to-send and answer-tone inputs are asynchronous. Each passes through a two-flop synchronizer before use.

Top module: `fsk_tone_mod`

## Requirements
- R1: A synchronous reset drives `tone_out` to 0 and `sample_stb` to 0 by the next clock edge, and leaves the controller in IDLE.
- R2: With `mode_bell`=0, `tx_data`=1 produces 1300 Hz and `tx_data`=0 produces 2100 Hz. `ans_en_n` has no effect in this mode.
- R3: With `mode_bell`=1 and `ans_en_n`=1, `tx_data`=1 produces 1200 Hz and `tx_data`=0 produces 2200 Hz.
- R4: With `mode_bell`=1, `ans_en_n`=0 and `rts_n`=0, the tone is 2025 Hz whatever the value of `tx_data`.
- R5: While `rts_n`=1 and no turn-off is in progress, `tone_out` is 0, whatever the other inputs do. Once a synchronized `rts_n`=0 is seen, the controller is in SEND on the next clock.
- R6: After `rts_n` rises, the amplitude scales linearly to zero over TURNOFF_US (500 us, which is 32 samples by default). It never rises during the ramp and then stays at 0. A low on `rts_n` during the ramp restores full scale.
- R7: A data change switches only the phase increment, never the accumulator. The accumulator moves only on sample strobes. Consecutive samples of a running tone differ by at most 32 codes across data transitions.
- R8: `tone_out` is two's complement. At full scale its peaks reach a magnitude of 120 to 127, and it never takes the value -128.
- R9: `sample_stb` pulses for one clock every SAMPLE_DIV (56) clocks, and `tone_out` changes only in the cycle where `sample_stb` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock (3.579545 MHz nominal) |
| rst | input | 1 | Synchronous reset, active high |
| mode_bell | input | 1 | Tone plan: 0 = 1300/2100 Hz plan, 1 = 1200/2200 Hz plan |
| tx_data | input | 1 | Serial data level, 1 = mark, asynchronous |
| rts_n | input | 1 | Request to send, active low, asynchronous |
| ans_en_n | input | 1 | Answer-tone request, active low, honoured in plan 1 only |
| tone_out | output | 8 | Signed sine-amplitude sample |
| sample_stb | output | 1 | One-clock strobe marking a new sample |

## Verification
The hardest case to reach is a data transition that lands at an arbitrary phase of the running tone. A phase break only shows as a jump when the tone is near a peak. The bench toggles `tx_data` after a varying number of sample strobes, so the transitions fall across many phases. It tracks the largest step between samples throughout. The soft turn-off is also hard to observe, because the tone crosses zero on its own. For this reason the bench judges the ramp by peak magnitudes over windows that are wide enough to hold a sine crest: an early window, a middle window and a late window.

// File: rtl/fsk_tone_pkg.sv
package fsk_tone_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_RAMP = 2'd2
    } gate_state_e;

    localparam int          GAIN_FRAC = 16;
    localparam int          GAIN_W    = GAIN_FRAC + 1;
    localparam logic [16:0] GAIN_FULL = 17'h10000;

    // Phase increment per sample: hz * 2^acc_w * div / clk_hz, rounded.
    function automatic logic [31:0] phase_step(input longint hz, input longint clk_hz,
                                               input longint div, input int acc_w);
        longint num;
        num = hz * (longint'(1) << acc_w) * div + clk_hz / 2;
        return 32'(num / clk_hz);
    endfunction

    // Quarter-wave magnitude at the centre of slot k (rational sine approximation).
    function automatic int quarter_sine(input int k, input int entries, input int amp);
        longint a, n, p, num, den;
        a   = 2 * k + 1;
        n   = 4 * entries;
        p   = a * (n - a);
        num = longint'(amp) * 16 * p;
        den = 5 * n * n - 4 * p;
        return int'((num + den / 2) / den);
    endfunction

endpackage

// File: rtl/fsk_tick_gen.sv
module fsk_tick_gen #(
    parameter int SAMPLE_DIV = 56
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CNT_W = $clog2(SAMPLE_DIV + 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || cnt == CNT_W'(SAMPLE_DIV - 1)) cnt <= '0;
        else                                      cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == CNT_W'(SAMPLE_DIV - 1));

    generate
        if (SAMPLE_DIV > 1) begin : g_spacing
            // R9
            tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/fsk_phase_acc.sv
module fsk_phase_acc import fsk_tone_pkg::*; #(
    parameter int CLK_HZ     = 3579545,
    parameter int SAMPLE_DIV = 56,
    parameter int ACC_W      = 24,
    parameter int IDX_W      = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             bell_mode,
    input  logic             data_bit,
    input  logic             ans_en_n,
    output logic [IDX_W-1:0] phase_idx
);
    localparam logic [ACC_W-1:0] STEP_1300 = ACC_W'(phase_step(1300, CLK_HZ, SAMPLE_DIV, ACC_W));
    localparam logic [ACC_W-1:0] STEP_2100 = ACC_W'(phase_step(2100, CLK_HZ, SAMPLE_DIV, ACC_W));
    localparam logic [ACC_W-1:0] STEP_1200 = ACC_W'(phase_step(1200, CLK_HZ, SAMPLE_DIV, ACC_W));
    localparam logic [ACC_W-1:0] STEP_2200 = ACC_W'(phase_step(2200, CLK_HZ, SAMPLE_DIV, ACC_W));
    localparam logic [ACC_W-1:0] STEP_2025 = ACC_W'(phase_step(2025, CLK_HZ, SAMPLE_DIV, ACC_W));

    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] step;

    // Only the increment follows the inputs; the accumulator is never cleared here.
    always_comb begin
        if (bell_mode) begin
            if (!ans_en_n)     step = STEP_2025;
            else if (data_bit) step = STEP_1200;
            else               step = STEP_2200;
        end else begin
            step = data_bit ? STEP_1300 : STEP_2100;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)       acc <= '0;
        else if (tick) acc <= acc + step;
    end

    assign phase_idx = acc[ACC_W-1 -: IDX_W];

    // R7
    acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> acc == $past(acc));
endmodule

// File: rtl/fsk_sine_lut.sv
module fsk_sine_lut import fsk_tone_pkg::*; #(
    parameter int IDX_W = 8,
    parameter int OUT_W = 8
) (
    input  logic [IDX_W-1:0]        phase_idx,
    output logic signed [OUT_W-1:0] sample
);
    localparam int Q_BITS  = IDX_W - 2;
    localparam int ENTRIES = 1 << Q_BITS;
    localparam int AMP     = (1 << (OUT_W - 1)) - 1;

    logic [OUT_W-2:0]        tbl [ENTRIES];
    logic [1:0]              quad;
    logic [Q_BITS-1:0]       slot;
    logic [OUT_W-2:0]        mag;
    logic signed [OUT_W-1:0] mag_s;

    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_tbl
            assign tbl[g] = (OUT_W-1)'(quarter_sine(g, ENTRIES, AMP));
        end
    endgenerate

    always_comb begin
        quad   = phase_idx[IDX_W-1 -: 2];
        slot   = phase_idx[Q_BITS-1:0];
        mag    = quad[0] ? tbl[~slot] : tbl[slot];
        mag_s  = $signed({1'b0, mag});
        sample = quad[1] ? -mag_s : mag_s;
    end
endmodule

// File: rtl/fsk_gate_fsm.sv
module fsk_gate_fsm import fsk_tone_pkg::*; #(
    parameter int CLK_HZ     = 3579545,
    parameter int SAMPLE_DIV = 56,
    parameter int TURNOFF_US = 500
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              tx_req,
    output logic [GAIN_W-1:0] gain
);
    localparam longint RAMP_RAW = (longint'(TURNOFF_US) * CLK_HZ
                                  + longint'(SAMPLE_DIV) * 500000)
                                  / (longint'(SAMPLE_DIV) * 1000000);
    localparam int RAMP_SAMPLES = (RAMP_RAW < 1) ? 1 : int'(RAMP_RAW);
    localparam int DEC          = ((1 << GAIN_FRAC) + RAMP_SAMPLES - 1) / RAMP_SAMPLES;
    localparam logic [GAIN_W-1:0] DEC_W = GAIN_W'(DEC);

    gate_state_e st, st_d;

    always_ff @(posedge clk) begin
        if (rst) st <= ST_IDLE;
        else     st <= st_d;
    end

    always_comb begin
        st_d = st;
        unique case (st)
            ST_IDLE: if (tx_req) st_d = ST_SEND;
            ST_SEND: if (!tx_req) st_d = ST_RAMP;
            ST_RAMP: begin
                if (tx_req)                     st_d = ST_SEND;
                else if (tick && gain <= DEC_W) st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gain <= '0;
        end else begin
            unique case (st_d)
                ST_IDLE: gain <= '0;
                ST_SEND: gain <= GAIN_FULL;
                ST_RAMP: if (tick && st == ST_RAMP) gain <= gain - DEC_W;
                default: gain <= '0;
            endcase
        end
    end

    // R6
    ramp_decay_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RAMP && !tx_req) |=> gain <= $past(gain));
    // R5
    send_on_request_chk: assert property (@(posedge clk) disable iff (rst)
        tx_req |=> st == ST_SEND);
endmodule

// File: rtl/fsk_tone_mod.sv
module fsk_tone_mod import fsk_tone_pkg::*; #(
    parameter int CLK_HZ     = 3579545,
    parameter int SAMPLE_DIV = 56,
    parameter int TURNOFF_US = 500,
    parameter int ACC_W      = 24,
    parameter int IDX_W      = 8,
    parameter int OUT_W      = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    mode_bell,
    input  logic                    tx_data,
    input  logic                    rts_n,
    input  logic                    ans_en_n,
    output logic signed [OUT_W-1:0] tone_out,
    output logic                    sample_stb
);
    localparam int PROD_W = OUT_W + GAIN_W + 1;

    logic [2:0] sync1, sync2;
    logic       tick;
    logic [IDX_W-1:0]        phase_idx;
    logic signed [OUT_W-1:0] sine;
    logic [GAIN_W-1:0]       gain;
    logic signed [PROD_W-1:0] prod;

    // Synchronizers: {data, rts_n, ans_en_n}; the idle values are mark and inactive.
    always_ff @(posedge clk) begin
        if (rst) begin
            sync1 <= 3'b111;
            sync2 <= 3'b111;
        end else begin
            sync1 <= {tx_data, rts_n, ans_en_n};
            sync2 <= sync1;
        end
    end

    fsk_tick_gen #(.SAMPLE_DIV(SAMPLE_DIV)) u_tick (
        .clk(clk), .rst(rst), .tick(tick)
    );

    fsk_phase_acc #(
        .CLK_HZ(CLK_HZ), .SAMPLE_DIV(SAMPLE_DIV), .ACC_W(ACC_W), .IDX_W(IDX_W)
    ) u_acc (
        .clk(clk), .rst(rst), .tick(tick), .bell_mode(mode_bell),
        .data_bit(sync2[2]), .ans_en_n(sync2[0]), .phase_idx(phase_idx)
    );

    fsk_sine_lut #(.IDX_W(IDX_W), .OUT_W(OUT_W)) u_lut (
        .phase_idx(phase_idx), .sample(sine)
    );

    fsk_gate_fsm #(
        .CLK_HZ(CLK_HZ), .SAMPLE_DIV(SAMPLE_DIV), .TURNOFF_US(TURNOFF_US)
    ) u_fsm (
        .clk(clk), .rst(rst), .tick(tick), .tx_req(!sync2[1]), .gain(gain)
    );

    assign prod = PROD_W'(sine) * $signed({1'b0, gain});

    always_ff @(posedge clk) begin
        if (rst) begin
            tone_out   <= '0;
            sample_stb <= 1'b0;
        end else begin
            sample_stb <= tick;
            if (tick) tone_out <= OUT_W'(prod >>> GAIN_FRAC);
        end
    end

    // R5
    idle_silent_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && gain == '0) |=> tone_out == '0);
    // R8
    no_min_code_chk: assert property (@(posedge clk) disable iff (rst)
        tone_out != {1'b1, {(OUT_W-1){1'b0}}});
    // R9
    out_on_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(tone_out));
endmodule

// File: tb/tb_fsk_tone_mod.sv
module tb_fsk_tone_mod;
    localparam real    MCLK_HZ = 3579545.0;
    localparam int     DIV     = 56;
    localparam int     NPER    = 3;
    localparam longint TOL     = 70;

    typedef struct packed {
        logic        bell;
        logic        data;
        logic        ans_n;
        logic [31:0] hz;
        logic [15:0] tag;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{1'b0, 1'b1, 1'b1, 32'd1300, "R2"},
        '{1'b0, 1'b0, 1'b1, 32'd2100, "R2"},
        '{1'b0, 1'b1, 1'b0, 32'd1300, "R2"},
        '{1'b1, 1'b1, 1'b1, 32'd1200, "R3"},
        '{1'b1, 1'b0, 1'b1, 32'd2200, "R3"},
        '{1'b1, 1'b1, 1'b0, 32'd2025, "R4"},
        '{1'b1, 1'b0, 1'b0, 32'd2025, "R4"}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mode_bell = 1'b0;
    logic tx_data = 1'b1;
    logic rts_n = 1'b1;
    logic ans_en_n = 1'b1;
    logic signed [7:0] tone_out;
    logic sample_stb;

    int     tests = 0;
    int     fails = 0;
    longint cyc = 0;
    bit     done = 1'b0;

    fsk_tone_mod dut (
        .clk(clk), .rst(rst), .mode_bell(mode_bell), .tx_data(tx_data),
        .rts_n(rts_n), .ans_en_n(ans_en_n), .tone_out(tone_out), .sample_stb(sample_stb)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 195000 && !done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected under 195000", cyc);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_clks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic int absv(input logic signed [7:0] v);
        return (v < 0) ? -int'(v) : int'(v);
    endfunction

    // Time NPER periods between upward zero crossings, and record the extremes seen.
    task automatic measure(output longint clks, output int hi, output int lo);
        logic signed [7:0] prev;
        longint t_first;
        int n;
        prev = 8'sd1; n = 0; t_first = 0; hi = -200; lo = 200;
        while (n <= NPER) begin
            @(negedge clk);
            if (sample_stb) begin
                if (prev < 0 && tone_out >= 0) begin
                    if (n == 0) t_first = cyc;
                    n++;
                end
                if (n > 0) begin
                    if (int'(tone_out) > hi) hi = int'(tone_out);
                    if (int'(tone_out) < lo) lo = int'(tone_out);
                end
                prev = tone_out;
            end
        end
        clks = cyc - t_first;
    endtask

    initial begin
        longint clks, exp, t0, last;
        int hi, lo, maxd, early, mid, late, a;
        logic signed [7:0] prev;

        // R1: values held in reset
        wait_clks(5);
        check(tone_out == 0, "R1", "tone_out in reset", tone_out, 0);
        check(sample_stb == 0, "R1", "sample_stb in reset", sample_stb, 0);
        rst = 1'b0;

        // R5: silent while request-to-send is inactive
        late = 0;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (tone_out != 0) late++;
        end
        check(late == 0, "R5", "nonzero samples after reset, rts_n high", late, 0);

        // R9: strobe spacing
        last = -1; a = 0;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (sample_stb) begin
                if (last >= 0 && cyc - last != DIV) a++;
                last = cyc;
            end
        end
        check(a == 0, "R9", "strobe intervals not equal to SAMPLE_DIV", a, 0);

        // Table of tone plans: R2, R3, R4 (frequency) and R8 (amplitude)
        rts_n = 1'b0;
        for (int v = 0; v < 7; v++) begin
            mode_bell = VECS[v].bell;
            tx_data   = VECS[v].data;
            ans_en_n  = VECS[v].ans_n;
            wait_clks(200);
            measure(clks, hi, lo);
            exp = longint'(NPER * MCLK_HZ / real'(VECS[v].hz));
            check((clks - exp <= TOL) && (exp - clks <= TOL), string'(VECS[v].tag),
                  $sformatf("period clocks for %0d Hz", VECS[v].hz), clks, exp);
            check(hi >= 120 && hi <= 127 && lo <= -120 && lo >= -127, "R8",
                  $sformatf("peak pair (hi*1000-lo) at %0d Hz", VECS[v].hz),
                  longint'(hi) * 1000 - lo, 127127);
        end

        // R7: data toggled at many phases, largest step between samples
        mode_bell = 1'b1; ans_en_n = 1'b1;
        maxd = 0; prev = tone_out;
        for (int t = 0; t < 40; t++) begin
            for (int s = 0; s < 5 + (t * 7) % 13; ) begin
                @(negedge clk);
                if (sample_stb) begin
                    if (absv(tone_out - prev) > maxd) maxd = absv(tone_out - prev);
                    prev = tone_out;
                    s++;
                end
            end
            tx_data = ~tx_data;
        end
        check(maxd <= 32, "R7", "largest step across data toggles", maxd, 32);

        // R6: soft turn-off after release
        tx_data = 1'b1;
        wait_clks(3000);
        rts_n = 1'b1;
        t0 = cyc; early = 0; mid = 0; late = 0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            a = absv(tone_out);
            if (cyc - t0 < 900) begin
                if (a > early) early = a;
            end else if (cyc - t0 >= 1100 && cyc - t0 < 1900) begin
                if (a > mid) mid = a;
            end else if (cyc - t0 >= 2000) begin
                if (a != 0) late++;
            end
        end
        check(early >= 40, "R6", "peak in first 900 clocks after release", early, 40);
        check(mid <= 60, "R6", "peak 1100..1900 clocks after release", mid, 60);
        check(late == 0, "R6", "nonzero samples after 2000 clocks", late, 0);

        // R6: re-request during the ramp restores full scale
        rts_n = 1'b0;
        wait_clks(3000);
        rts_n = 1'b1;
        wait_clks(500);
        rts_n = 1'b0;
        wait_clks(200);
        measure(clks, hi, lo);
        check(hi >= 120 && lo <= -120, "R6", "peak after re-request (hi)", hi, 127);

        // R5: inactive request with answer tone asked and data moving
        rts_n = 1'b1; ans_en_n = 1'b0;
        wait_clks(2200);
        late = 0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (i % 97 == 0) tx_data = ~tx_data;
            if (tone_out != 0) late++;
        end
        check(late == 0, "R5", "nonzero samples with rts_n high", late, 0);

        // R1: reset in the middle of a running tone
        rts_n = 1'b0; ans_en_n = 1'b1;
        wait_clks(1500);
        rst = 1'b1;
        @(negedge clk);
        check(tone_out == 0, "R1", "tone_out after mid-run reset", tone_out, 0);
        check(sample_stb == 0, "R1", "sample_stb after mid-run reset", sample_stb, 0);
        rst = 1'b0;
        wait_clks(10);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule